// File: doc/BRIEF.md
# External Interrupt Sense and Status Unit

This block sits between a set of interrupt pins and a parent interrupt controller. It watches one non-maskable pin and a parameterised number of external interrupt pins (eight by default). Each pin is brought into the clock domain through a two-flop synchroniser. A programmable sense mode then decides what counts as an event on that pin, a status bit records the event, and an active-high level request goes to the parent controller.

Software programs sense modes, reads and clears status bits, and masks external requests over a simple single-cycle 32-bit register bus. Writes are accepted on the cycle where `bus_we` is high. Reads are combinational from `bus_addr`.

A status bit that was latched by an edge stays set until software clears it by writing a zero to that bit. In low-level mode the status bit instead tracks the pin, so a clear write there does nothing.

Top module: `ext_irq_sense_unit`

## Requirements
- R1: After reset every register reads 0, both requests are low, and the synchroniser and edge-history flops hold 1, so an idle-high pin raises nothing.
- R2: A pin change reaches its status bit on the third rising clock edge after the change is applied (two synchroniser flops, then the edge-history compare).
- R3: The external sense register at offset 0x14 holds a 2-bit code for channel n at bits [2n+1:2n], and it reads back what was written. The codes are 0 = low level, 1 = falling edge, 2 = rising edge, 3 = both edges.
- R4: In low-level mode (code 0) a channel's status bit equals the inverted synchronised pin. Writing 0 to it through offset 0x10 has no effect.
- R5: In an edge mode a channel's status bit (offset 0x10, bit n) is set only by the selected edge and holds until cleared. Writing 0 to bit n clears it. Writing 1 has no effect.
- R6: When a clear write and a new selected edge fall in the same cycle, the status bit stays set.
- R7: The mask register at offset 0x10010 has one bit per channel. A 1 forces `ext_req[n]` low without changing the status bit, so `ext_req[n]` equals status AND NOT mask.
- R8: The non-maskable sense register at offset 0x4 bit 0 selects falling edge (0) or rising edge (1). Its status flag is offset 0x0 bit 0, and `nmi_req` equals that flag.
- R9: The non-maskable status flag is cleared only by writing 0 to bit 0 of offset 0x0 while it is 1. Writing 1 leaves it unchanged.
- R10: Unmapped addresses and unused bits of mapped registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (17) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| nmi_pin | input | 1 | Asynchronous non-maskable interrupt pin |
| ext_pin | input | NUM_CH (8) | Asynchronous external interrupt pins |
| nmi_req | output | 1 | Active-high request for the non-maskable source |
| ext_req | output | NUM_CH (8) | Active-high per-channel requests after masking |

## Verification
Every channel is put in a different sense mode at the same time, and each pin is driven both high-to-low and low-to-high. This shows that only the selected edge latches a status bit and that the opposite edge is ignored. Clear writes are tried with 1s, with 0s, in low-level mode, and in the exact cycle a new edge is detected. These cases separate the clear-only-if-set-and-edge rule from the edge-wins rule. Masking is toggled while a status bit is held, which shows that the request and the status bit are independent. The non-maskable path is tried in both of its edge modes.

// File: rtl/eisu_pkg.sv
package eisu_pkg;

    // Per-channel sense codes; the values are the register encoding.
    typedef enum logic [1:0] {
        SNS_LEVEL_LOW = 2'd0,
        SNS_EDGE_FALL = 2'd1,
        SNS_EDGE_RISE = 2'd2,
        SNS_EDGE_BOTH = 2'd3
    } sense_e;

    localparam logic [31:0] OFS_NMI_STAT  = 32'h0000_0000;
    localparam logic [31:0] OFS_NMI_SENSE = 32'h0000_0004;
    localparam logic [31:0] OFS_EXT_STAT  = 32'h0000_0010;
    localparam logic [31:0] OFS_EXT_SENSE = 32'h0000_0014;
    localparam logic [31:0] OFS_EXT_MASK  = 32'h0001_0010;

endpackage

// File: rtl/eisu_sync.sv
module eisu_sync #(
    parameter int   WIDTH   = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stg;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.stg[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.stg[i] = s_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.stg <= {(STAGES*WIDTH){RST_VAL}};
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_o = s_q.stg[STAGES-1];

endmodule

// File: rtl/eisu_edge_chan.sv
module eisu_edge_chan
    import eisu_pkg::*;
#(
    parameter logic PREV_RST = 1'b1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   lvl_i,     // synchronised pin
    input  sense_e sense_i,
    input  logic   clr_i,     // bus wrote 0 to this status bit
    output logic   status_o
);

    typedef struct packed {
        logic prev;
        logic status;
    } chan_t;

    chan_t st_d, st_q;
    logic  fall, rise, hit, is_edge, clr_ok;

    always_comb begin
        fall    = st_q.prev & ~lvl_i;
        rise    = ~st_q.prev & lvl_i;
        is_edge = (sense_i != SNS_LEVEL_LOW);
        unique case (sense_i)
            SNS_EDGE_FALL: hit = fall;
            SNS_EDGE_RISE: hit = rise;
            SNS_EDGE_BOTH: hit = fall | rise;
            default:       hit = 1'b0;
        endcase
        // clearing needs a set flag and an edge mode
        clr_ok = clr_i & st_q.status & is_edge;

        st_d      = st_q;
        st_d.prev = lvl_i;
        if (is_edge) begin
            st_d.status = hit | (st_q.status & ~clr_ok);
        end else begin
            st_d.status = ~lvl_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev   <= PREV_RST;
            st_q.status <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;

    // R4: low level mode tracks the inverted synchronised pin
    assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_i == SNS_LEVEL_LOW) |=> (status_o == !$past(lvl_i)));

    // R5: an edge-mode flag holds unless a clear is requested
    assert_edge_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_i != SNS_LEVEL_LOW && status_o && !clr_i) |=> status_o);

    // R5: an edge-mode flag rises only on a selected edge
    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_i != SNS_LEVEL_LOW && !status_o && !hit) |=> !status_o);

    // R6: a new edge beats a simultaneous clear
    assert_edge_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_i != SNS_LEVEL_LOW && hit && clr_i) |=> status_o);

endmodule

// File: rtl/eisu_regs.sv
module eisu_regs
    import eisu_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 17
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_we,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NUM_CH-1:0]      ext_status_i,
    input  logic                   nmi_status_i,
    output logic [NUM_CH-1:0][1:0] ext_sense_o,
    output logic                   nmi_rise_o,
    output logic [NUM_CH-1:0]      ext_mask_o,
    output logic [NUM_CH-1:0]      ext_clr_o,
    output logic                   nmi_clr_o
);

    localparam int SENSE_W = 2 * NUM_CH;   // NUM_CH must not exceed 16

    typedef struct packed {
        logic                   nmi_rise;
        logic [NUM_CH-1:0][1:0] sense;
        logic [NUM_CH-1:0]      mask;
    } regs_t;

    regs_t r_d, r_q;
    logic [31:0] addr_ext;
    logic sel_nstat, sel_nsense, sel_estat, sel_esense, sel_mask;
    logic unused_wdata;

    assign addr_ext     = 32'(bus_addr);
    assign sel_nstat    = (addr_ext == OFS_NMI_STAT);
    assign sel_nsense   = (addr_ext == OFS_NMI_SENSE);
    assign sel_estat    = (addr_ext == OFS_EXT_STAT);
    assign sel_esense   = (addr_ext == OFS_EXT_SENSE);
    assign sel_mask     = (addr_ext == OFS_EXT_MASK);
    assign unused_wdata = ^bus_wdata;

    always_comb begin
        r_d = r_q;
        if (bus_we && sel_nsense) r_d.nmi_rise = bus_wdata[0];
        if (bus_we && sel_esense) r_d.sense    = bus_wdata[SENSE_W-1:0];
        if (bus_we && sel_mask)   r_d.mask     = bus_wdata[NUM_CH-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_nstat) begin
            bus_rdata[0] = nmi_status_i;
        end else if (sel_nsense) begin
            bus_rdata[0] = r_q.nmi_rise;
        end else if (sel_estat) begin
            bus_rdata[NUM_CH-1:0] = ext_status_i;
        end else if (sel_esense) begin
            bus_rdata[SENSE_W-1:0] = r_q.sense;
        end else if (sel_mask) begin
            bus_rdata[NUM_CH-1:0] = r_q.mask;
        end
    end

    assign ext_sense_o = r_q.sense;
    assign nmi_rise_o  = r_q.nmi_rise;
    assign ext_mask_o  = r_q.mask;
    assign ext_clr_o   = {NUM_CH{bus_we & sel_estat}} & ~bus_wdata[NUM_CH-1:0];
    assign nmi_clr_o   = bus_we & sel_nstat & ~bus_wdata[0];

    // R7: a mask write lands in the mask register on the next cycle
    assert_mask_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel_mask) |=> (ext_mask_o == $past(bus_wdata[NUM_CH-1:0])));

    // R8: the non-maskable edge select follows its register write
    assert_nmi_sense_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel_nsense) |=> (nmi_rise_o == $past(bus_wdata[0])));

endmodule

// File: rtl/ext_irq_sense_unit.sv
module ext_irq_sense_unit
    import eisu_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              nmi_pin,
    input  logic [NUM_CH-1:0] ext_pin,
    output logic              nmi_req,
    output logic [NUM_CH-1:0] ext_req
);

    localparam int PIN_W = NUM_CH + 1;   // top bit carries the non-maskable pin

    logic [PIN_W-1:0]       pin_sync;
    logic [NUM_CH-1:0][1:0] ext_sense;
    logic [NUM_CH-1:0]      ext_mask, ext_clr, ext_status;
    logic                   nmi_rise, nmi_clr, nmi_status;
    sense_e                 nmi_sense;

    eisu_sync #(.WIDTH(PIN_W), .STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({nmi_pin, ext_pin}),
        .sync_o  (pin_sync)
    );

    eisu_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .ext_status_i (ext_status),
        .nmi_status_i (nmi_status),
        .ext_sense_o  (ext_sense),
        .nmi_rise_o   (nmi_rise),
        .ext_mask_o   (ext_mask),
        .ext_clr_o    (ext_clr),
        .nmi_clr_o    (nmi_clr)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        eisu_edge_chan #(.PREV_RST(1'b1)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl_i    (pin_sync[n]),
            .sense_i  (sense_e'(ext_sense[n])),
            .clr_i    (ext_clr[n]),
            .status_o (ext_status[n])
        );
    end

    // the non-maskable source only has the two edge modes
    assign nmi_sense = nmi_rise ? SNS_EDGE_RISE : SNS_EDGE_FALL;

    eisu_edge_chan #(.PREV_RST(1'b1)) u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (pin_sync[NUM_CH]),
        .sense_i  (nmi_sense),
        .clr_i    (nmi_clr),
        .status_o (nmi_status)
    );

    assign ext_req = ext_status & ~ext_mask;
    assign nmi_req = nmi_status;

    // R9: the non-maskable request only drops after a zero write to its flag
    assert_nmi_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !(bus_we && 32'(bus_addr) == OFS_NMI_STAT && !bus_wdata[0]))
        |=> nmi_req);

endmodule

// File: tb/ext_irq_sense_unit_bench.sv
module ext_irq_sense_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [16:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        nmi_pin = 1'b1;
    logic [7:0]  ext_pin = 8'hFF;
    logic        nmi_req;
    logic [7:0]  ext_req;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;   // 20 ns period

    ext_irq_sense_unit u_ext_irq_sense_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .nmi_pin   (nmi_pin),
        .ext_pin   (ext_pin),
        .nmi_req   (nmi_req),
        .ext_req   (ext_req)
    );

    // ---------------- behavioural reference model ----------------
    logic [8:0]  m_s1 = '1, m_s2 = '1, m_prev = '1;
    logic [7:0]  m_stat = '0, m_mask = '0;
    logic [15:0] m_sense = '0;
    logic        m_nstat = 1'b0, m_nsense = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        int  code;
        bit  cur, prv, hit, clr;
        if (!rst_n) begin
            m_s1 = '1; m_s2 = '1; m_prev = '1;
            m_stat = '0; m_mask = '0; m_sense = '0;
            m_nstat = 1'b0; m_nsense = 1'b0;
        end else begin
            for (int n = 0; n < 8; n++) begin
                cur  = m_s2[n];
                prv  = m_prev[n];
                code = int'(m_sense[2*n +: 2]);
                if (code == 0) begin
                    m_stat[n] = !cur;
                end else begin
                    hit = (code == 1 && prv && !cur) || (code == 2 && !prv && cur) ||
                          (code == 3 && prv != cur);
                    clr = bus_we && bus_addr == 17'h10 && !bus_wdata[n] && m_stat[n];
                    m_stat[n] = hit || (m_stat[n] && !clr);
                end
            end
            cur = m_s2[8];
            prv = m_prev[8];
            hit = m_nsense ? (!prv && cur) : (prv && !cur);
            clr = bus_we && bus_addr == 17'h0 && !bus_wdata[0] && m_nstat;
            m_nstat = hit || (m_nstat && !clr);
            if (bus_we && bus_addr == 17'h4)     m_nsense = bus_wdata[0];
            if (bus_we && bus_addr == 17'h14)    m_sense  = bus_wdata[15:0];
            if (bus_we && bus_addr == 17'h10010) m_mask   = bus_wdata[7:0];
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = {nmi_pin, ext_pin};
        end
    end

    function automatic logic [31:0] model_read(input logic [16:0] a);
        case (a)
            17'h0:     return {31'b0, m_nstat};
            17'h4:     return {31'b0, m_nsense};
            17'h10:    return {24'b0, m_stat};
            17'h14:    return {16'b0, m_sense};
            17'h10010: return {24'b0, m_mask};
            default:   return 32'h0;
        endcase
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every clock, compare both requests with the model (R7, R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 ext_req vs status and mask", {24'b0, ext_req}, {24'b0, m_stat & ~m_mask});
            chk("R8 nmi_req vs flag", {31'b0, nmi_req}, {31'b0, m_nstat});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [16:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [16:0] a, input string tag, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        chk({tag, " model"}, bus_rdata, model_read(a));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rd(17'h0,     "R1 nmi status reset", 32'h0);
        rd(17'h4,     "R1 nmi sense reset",  32'h0);
        rd(17'h10,    "R1 ext status reset", 32'h0);
        rd(17'h14,    "R1 ext sense reset",  32'h0);
        rd(17'h10010, "R1 mask reset",       32'h0);
        chk("R1 requests low", {23'b0, nmi_req, ext_req}, 32'h0);

        // R10 unmapped addresses
        rd(17'h8,     "R10 unmapped 0x8",     32'h0);
        rd(17'h18,    "R10 unmapped 0x18",    32'h0);
        rd(17'h1FFFC, "R10 unmapped 0x1fffc", 32'h0);

        // R2 latency and R4 low level on channel 0
        ext_pin[0] = 1'b0;
        tick(1); rd(17'h10, "R2 after one edge",    32'h0);
        tick(1); rd(17'h10, "R2 after two edges",   32'h0);
        tick(1); rd(17'h10, "R2 after three edges", 32'h1);
        wr(17'h10, 32'h0);
        rd(17'h10, "R4 clear ignored in level mode", 32'h1);
        ext_pin[0] = 1'b1;
        tick(3);
        rd(17'h10, "R4 level released", 32'h0);

        // R3 sense codes: ch0 low, ch1 falling, ch2 rising, ch3 both
        wr(17'h14, 32'h0000_00E4);
        rd(17'h14, "R3 sense readback", 32'h0000_00E4);

        // R5 falling edge on channel 1
        ext_pin[1] = 1'b0;
        tick(3);
        rd(17'h10, "R5 falling sets ch1", 32'h2);
        ext_pin[1] = 1'b1;
        tick(4);
        rd(17'h10, "R5 ch1 holds after pin returns", 32'h2);
        wr(17'h10, 32'hFFFF_FFFF);
        rd(17'h10, "R5 write one has no effect", 32'h2);
        wr(17'h10, ~32'h2);
        rd(17'h10, "R5 write zero clears ch1", 32'h0);

        // R3 rising-only on channel 2
        ext_pin[2] = 1'b0;
        tick(4);
        rd(17'h10, "R3 rising mode ignores falling", 32'h0);
        ext_pin[2] = 1'b1;
        tick(3);
        rd(17'h10, "R3 rising mode sets ch2", 32'h4);
        wr(17'h10, ~32'h4);

        // R3 both edges on channel 3
        ext_pin[3] = 1'b0;
        tick(3);
        rd(17'h10, "R3 both mode on falling", 32'h8);
        wr(17'h10, ~32'h8);
        rd(17'h10, "R5 ch3 cleared", 32'h0);
        ext_pin[3] = 1'b1;
        tick(3);
        rd(17'h10, "R3 both mode on rising", 32'h8);

        // R6 clear lands in the cycle a new edge is detected
        ext_pin[3] = 1'b0;
        tick(2);
        wr(17'h10, ~32'h8);
        rd(17'h10, "R6 edge beats clear", 32'h8);
        wr(17'h10, ~32'h8);
        rd(17'h10, "R6 later clear works", 32'h0);

        // R7 masking
        ext_pin[1] = 1'b0;
        tick(3);
        wr(17'h10010, 32'h2);
        rd(17'h10010, "R7 mask readback", 32'h2);
        chk("R7 masked request low", {24'b0, ext_req}, 32'h0);
        rd(17'h10, "R7 status kept under mask", 32'h2);
        wr(17'h10010, 32'h0);
        chk("R7 unmasked request high", {24'b0, ext_req}, 32'h2);

        // R8 non-maskable falling (default)
        nmi_pin = 1'b0;
        tick(3);
        rd(17'h0, "R8 falling sets flag", 32'h1);
        chk("R8 nmi_req high", {31'b0, nmi_req}, 32'h1);
        // R9 clear rules
        wr(17'h0, 32'h1);
        rd(17'h0, "R9 write one keeps flag", 32'h1);
        wr(17'h0, 32'h0);
        rd(17'h0, "R9 write zero clears flag", 32'h0);

        // R8 rising mode and R10 reserved bits
        wr(17'h4, 32'hFFFF_FFFF);
        rd(17'h4, "R10 only bit 0 of nmi sense", 32'h1);
        nmi_pin = 1'b1;
        tick(3);
        rd(17'h0, "R8 rising sets flag", 32'h1);
        wr(17'h0, 32'h0);
        nmi_pin = 1'b0;
        tick(4);
        rd(17'h0, "R8 rising mode ignores falling", 32'h0);

        // R10 reserved bits of mask
        wr(17'h10010, 32'hFFFF_FF00);
        rd(17'h10010, "R10 mask upper bits", 32'h0);

        tick(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule